// File: doc/BRIEF.md
# Receive Buffer Ring Writer

This block moves received Ethernet frames, presented one byte per cycle on a valid/ready stream, into system memory through a ring of fixed-size receive buffers. Each ring slot is a pair of 32-bit words in memory. The first word holds the buffer address, with the low two bits reused as flags. The second word receives a status value that the engine writes. Software sets a ring base. It hands a slot to the engine by clearing the slot's ownership bit, and it takes the slot back once the engine has set that bit again.

A frame longer than one buffer continues into the buffers of the following slots. The first buffer of a frame and the last buffer of a frame are each marked in their status words. The total length and the destination-match flags are written only in the slot that ends the frame. If the engine meets a slot that software still owns, it discards the rest of the frame, reports an overrun pulse and stays on that slot. The memory port is single-cycle: a write completes at the edge where it is issued, and read data is valid in the cycle after the read request.

Top module: `rxring_dma_writer`

## Requirements
- R1: Each buffer receives at most 128 bytes. Byte 129 onward continues in the next slot's buffer. The status word of a buffer that neither starts nor ends a frame is written as 0.
- R2: If the slot read at the start of a frame has address-word bit 0 set, nothing is written to memory. The whole frame is consumed and discarded, `overrun` is high for exactly one cycle, and the next frame uses the same slot.
- R3: After a buffer is filled, the slot's address word is written back with bit 0 set and every other bit unchanged. This write comes in the cycle directly after that slot's status-word write, which is at slot address + 4.
- R4: After a slot whose address-word bit 1 is set, the next slot used is the one at `ring_base`. Otherwise it is the slot at the previous slot address + 8.
- R5: The status word of the slot that ends a frame carries the total frame length in bytes in bits 11:0. No other slot of the frame carries a length.
- R6: Status bit 14 is set only in the frame's first buffer. Status bit 15 is set only in its last buffer. A frame that fits in one buffer has both bits set.
- R7: In the ending slot, status bit 31 holds `in_bcast`, bit 22 holds `in_tmatch`, and bits 26, 25, 24 and 23 hold `in_amatch[0]`, `[1]`, `[2]` and `[3]`. All of these are sampled with the byte that has `in_last` set.
- R8: The buffer address is the address word with bits 1:0 cleared. Frame byte k of a buffer goes to buffer address + k, in little-endian byte lanes, so lane k mod 4 of the aligned word.
- R9: Only the bytes of the frame are written. Byte enables cover exactly those bytes, and memory past the frame end inside the last buffer keeps its old contents.
- R10: If the slot fetched for the continuation of a frame is still owned, the rest of the frame is discarded and `overrun` pulses for one cycle. The position stays on that owned slot. The buffers already filled keep their written status and ownership.
- R11: While `en` is low and no frame is in progress, no frame is started, `in_ready` stays low and no memory request is made.
- R12: After reset, `mem_req`, `in_ready` and `overrun` are low, and the first frame uses the slot at `ring_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new frames to start |
| ring_base | input | AW | Byte address of the first ring slot |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the frame's final byte |
| in_bcast | input | 1 | Broadcast destination flag, sampled with the final byte |
| in_amatch | input | 4 | Specific-address match flags 1 to 4, sampled with the final byte |
| in_tmatch | input | 1 | Type-ID match flag, sampled with the final byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| overrun | output | 1 | One-cycle pulse when a frame is cut short by an owned slot |

## Verification
The assertions check the per-cycle rules. The fill offset never passes the buffer size. Every write carries a byte enable, and data words are aligned. The overrun signal never lasts two cycles. The ownership write always follows the status write. Nothing is requested while the engine is idle and disabled. Taking the wrap flag returns the position to the ring base. Only the bench scenarios can show the rules that depend on memory contents across whole frames: the split of a 300-byte frame over three buffers with the right start and end marks, the wrap at the flagged slot, bytes past a frame end left unchanged, and the slot position held across both kinds of overrun.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  localparam int WORD_W     = 32;
  localparam int LANES      = WORD_W / 8;

  // address-word flag bits
  localparam int OWN_BIT    = 0;
  localparam int LAST_BIT   = 1;

  // status-word bit positions (decoded by software)
  localparam int SOF_BIT    = 14;
  localparam int EOF_BIT    = 15;
  localparam int TYPE_BIT   = 22;
  localparam int AMATCH_TOP = 26;
  localparam int BCAST_BIT  = 31;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_FILL,
    S_PUT,
    S_STAT,
    S_OWN,
    S_DROP
  } rx_state_e;

endpackage

// File: rtl/rxr_byte_pack.sv
module rxr_byte_pack
  import rxring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld,
  input  logic [1:0]        lane,
  input  logic [7:0]        din,
  output logic [WORD_W-1:0] word,
  output logic [LANES-1:0]  be
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_q, byte_n;
    logic       en_q, en_n;
    logic       hit;

    assign hit = ld && (lane == 2'(g));

    always_comb begin
      byte_n = byte_q;
      en_n   = en_q;
      if (clr) begin
        en_n = 1'b0;
      end else if (hit) begin
        byte_n = din;
        en_n   = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        en_q   <= 1'b0;
      end else begin
        byte_q <= byte_n;
        en_q   <= en_n;
      end
    end

    assign word[g*8 +: 8] = byte_q;
    assign be[g]          = en_q;
  end

endmodule

// File: rtl/rxr_desc_ptr.sv
module rxr_desc_ptr #(
  parameter int AW    = 32,
  parameter int IDX_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] desc_addr
);

  logic [IDX_W-1:0] idx_q, idx_n;

  always_comb begin
    idx_n = idx_q;
    if (adv) begin
      idx_n = wrap ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_n;
  end

  assign desc_addr = base + {{(AW-IDX_W-3){1'b0}}, idx_q, 3'b000};

  // R4: taking the wrap flag brings the position back to the ring base
  a_r4_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap) |=> (idx_q == '0));

endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt
  import rxring_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic              first,
  input  logic              last,
  input  logic [LEN_W-1:0]  len,
  input  logic              bcast,
  input  logic [3:0]        amatch,
  input  logic              tmatch,
  output logic [WORD_W-1:0] status
);

  always_comb begin
    status          = '0;
    status[SOF_BIT] = first;
    if (last) begin
      status[EOF_BIT]     = 1'b1;
      status[LEN_W-1:0]   = len;
      status[BCAST_BIT]   = bcast;
      status[TYPE_BIT]    = tmatch;
      for (int j = 0; j < 4; j++) begin
        status[AMATCH_TOP-j] = amatch[j];
      end
    end
  end

endmodule

// File: rtl/rxring_dma_writer.sv
module rxring_dma_writer
  import rxring_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 128,
  parameter int IDX_W     = 10,
  parameter int LEN_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [AW-1:0]     ring_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_bcast,
  input  logic [3:0]        in_amatch,
  input  logic              in_tmatch,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              overrun
);

  localparam int OFF_W = $clog2(BUF_BYTES);

  rx_state_e          state_q, state_n;
  logic [OFF_W:0]     off_q, off_n;
  logic [OFF_W-1:0]   put_ofs_q, put_ofs_n;
  logic [LEN_W-1:0]   flen_q, flen_n;
  logic               first_q, first_n;
  logic               end_q, end_n;
  logic [WORD_W-1:0]  aword_q, aword_n;
  logic               bcast_q, bcast_n;
  logic [3:0]         amatch_q, amatch_n;
  logic               tmatch_q, tmatch_n;
  logic               ovr_q, ovr_n;

  logic               pk_clr, pk_ld;
  logic [WORD_W-1:0]  pk_word;
  logic [LANES-1:0]   pk_be;
  logic               ptr_adv;
  logic [AW-1:0]      desc_addr;
  logic [AW-1:0]      buf_base;
  logic [WORD_W-1:0]  status;
  logic               buf_full;
  logic               buf_edge;

  assign buf_base = {aword_q[AW-1:2], 2'b00};
  assign buf_full = (off_q == (OFF_W+1)'(BUF_BYTES));
  assign buf_edge = (off_q == (OFF_W+1)'(BUF_BYTES-1));

  rxr_byte_pack u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pk_clr),
    .ld    (pk_ld),
    .lane  (off_q[1:0]),
    .din   (in_data),
    .word  (pk_word),
    .be    (pk_be)
  );

  rxr_desc_ptr #(.AW(AW), .IDX_W(IDX_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (ptr_adv),
    .wrap      (aword_q[LAST_BIT]),
    .base      (ring_base),
    .desc_addr (desc_addr)
  );

  rxr_status_fmt #(.LEN_W(LEN_W)) u_fmt (
    .first  (first_q),
    .last   (end_q),
    .len    (flen_q),
    .bcast  (bcast_q),
    .amatch (amatch_q),
    .tmatch (tmatch_q),
    .status (status)
  );

  always_comb begin
    state_n   = state_q;
    off_n     = off_q;
    put_ofs_n = put_ofs_q;
    flen_n    = flen_q;
    first_n   = first_q;
    end_n     = end_q;
    aword_n   = aword_q;
    bcast_n   = bcast_q;
    amatch_n  = amatch_q;
    tmatch_n  = tmatch_q;
    ovr_n     = 1'b0;
    in_ready  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    mem_be    = '0;
    pk_clr    = 1'b0;
    pk_ld     = 1'b0;
    ptr_adv   = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (en && in_valid) begin
          state_n = S_FETCH;
          first_n = 1'b1;
          end_n   = 1'b0;
          flen_n  = '0;
        end
      end
      S_FETCH: begin
        mem_req = 1'b1;
        state_n = S_CHECK;
      end
      S_CHECK: begin
        if (mem_rdata[OWN_BIT]) begin
          ovr_n   = 1'b1;
          state_n = S_DROP;
        end else begin
          aword_n = mem_rdata;
          off_n   = '0;
          pk_clr  = 1'b1;
          state_n = S_FILL;
        end
      end
      S_FILL: begin
        in_ready = 1'b1;
        if (in_valid) begin
          pk_ld     = 1'b1;
          put_ofs_n = {off_q[OFF_W-1:2], 2'b00};
          off_n     = off_q + 1'b1;
          flen_n    = flen_q + 1'b1;
          if (in_last) begin
            end_n    = 1'b1;
            bcast_n  = in_bcast;
            amatch_n = in_amatch;
            tmatch_n = in_tmatch;
          end
          if ((off_q[1:0] == 2'b11) || in_last || buf_edge) begin
            state_n = S_PUT;
          end
        end
      end
      S_PUT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_base + {{(AW-OFF_W){1'b0}}, put_ofs_q};
        mem_wdata = pk_word;
        mem_be    = pk_be;
        pk_clr    = 1'b1;
        state_n   = (end_q || buf_full) ? S_STAT : S_FILL;
      end
      S_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + AW'(4);
        mem_wdata = status;
        mem_be    = '1;
        state_n   = S_OWN;
      end
      S_OWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = aword_q | WORD_W'(1);
        mem_be    = '1;
        ptr_adv   = 1'b1;
        first_n   = 1'b0;
        state_n   = end_q ? S_IDLE : S_FETCH;
      end
      S_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) begin
          state_n = S_IDLE;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      off_q     <= '0;
      put_ofs_q <= '0;
      flen_q    <= '0;
      first_q   <= 1'b0;
      end_q     <= 1'b0;
      aword_q   <= '0;
      bcast_q   <= 1'b0;
      amatch_q  <= '0;
      tmatch_q  <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      state_q   <= state_n;
      off_q     <= off_n;
      put_ofs_q <= put_ofs_n;
      flen_q    <= flen_n;
      first_q   <= first_n;
      end_q     <= end_n;
      aword_q   <= aword_n;
      bcast_q   <= bcast_n;
      amatch_q  <= amatch_n;
      tmatch_q  <= tmatch_n;
      ovr_q     <= ovr_n;
    end
  end

  assign overrun = ovr_q;

  a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= (OFF_W+1)'(BUF_BYTES));

  a_r2_overrun_single: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);

  a_r3_own_after_status: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_OWN) |-> ($past(state_q) == S_STAT));

  a_r8_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[1:0] == 2'b00));

  a_r9_be_present: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != '0));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !en) |=> !mem_req);

endmodule

// File: tb/rxring_dma_writer_bench.sv
module rxring_dma_writer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [31:0] ring_base;
  logic        in_valid, in_last, in_bcast, in_tmatch;
  logic [7:0]  in_data;
  logic [3:0]  in_amatch;
  logic        in_ready, mem_req, mem_we, overrun;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxring_dma_writer u_rxring_dma_writer (
    .clk(clk), .rst_n(rst_n), .en(en), .ring_base(ring_base),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_bcast(in_bcast), .in_amatch(in_amatch), .in_tmatch(in_tmatch),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata), .overrun(overrun)
  );

  logic [31:0] m [0:1023];
  logic [63:0] exp_q [$];
  int          n_chk = 0, n_bad = 0, n_wr = 0, n_ovr = 0;
  logic [31:0] prev_wr_addr = 32'hFFFF_FFFF;
  logic        poke_go = 1'b0;
  logic [31:0] poke_a, poke_d;
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and scoreboard monitor, all at the falling edge
  always @(negedge clk) begin
    if (poke_go) m[poke_a[11:2]] = poke_d;
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) m[mem_addr[11:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
        n_wr++;
        if (mem_addr >= 32'h100 && mem_addr < 32'h120) begin
          if (mem_addr[2]) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected status write", mem_addr, 32'h0);
            else begin
              logic [63:0] e;
              e = exp_q.pop_front();
              chk(mem_addr == e[63:32], "R4 status slot address", mem_addr, e[63:32]);
              chk(mem_wdata == e[31:0], "R5/R6 status word", mem_wdata, e[31:0]);
            end
          end else begin
            chk(mem_wdata[0] && prev_wr_addr == mem_addr + 32'd4,
                "R3 ownership write after status", prev_wr_addr, mem_addr + 32'd4);
          end
        end
        prev_wr_addr = mem_addr;
      end else begin
        mem_rdata = m[mem_addr[11:2]];
      end
    end
    if (overrun) n_ovr++;
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    poke_a = a; poke_d = d; poke_go = 1'b1;
    @(negedge clk); #1;
    poke_go = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int fid, input int k);
    return 8'((fid * 31 + k * 7 + 1) & 255);
  endfunction

  function automatic logic [7:0] mb(input int a);
    return m[a >> 2][(a % 4) * 8 +: 8];
  endfunction

  task automatic send_byte(input logic [7:0] d, input logic l);
    in_valid = 1'b1; in_data = d; in_last = l;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_frame(input int fid, input int len);
    for (int k = 0; k < len; k++) send_byte(pat(fid, k), k == len - 1);
    repeat (12) @(negedge clk);
    #1;
  endtask

  task automatic check_seg(input string req, input int fid, input int k0, input int n, input int baddr);
    int bad = 0;
    int first_bad = -1;
    for (int k = k0; k < k0 + n; k++)
      if (mb(baddr + k - k0) !== pat(fid, k)) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
    chk(bad == 0, req, 32'(bad), 32'(first_bad < 0 ? 0 : first_bad));
  endtask

  task automatic check_clean(input string req, input int a, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mb(a + i) !== 8'hA5) bad++;
    chk(bad == 0, req, 32'(bad), 32'h0);
  endtask

  initial begin
    int          wr0, ov0;
    logic        saw_ready;
    rst_n = 1'b0; en = 1'b0; ring_base = 32'h100;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    in_bcast = 1'b0; in_amatch = '0; in_tmatch = 1'b0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R12: quiet after reset
    chk(!mem_req && !in_ready && !overrun, "R12 reset outputs",
        {29'b0, mem_req, in_ready, overrun}, 32'h0);

    for (int a = 32'h400; a < 32'h600; a += 4) poke(a, 32'hA5A5A5A5);
    for (int i = 0; i < 4; i++)
      poke(32'h100 + 8 * i, 32'h400 + 32'h80 * i + (i == 3 ? 2 : 0));
    for (int i = 0; i < 4; i++) poke(32'h104 + 8 * i, 32'h0);
    en = 1'b1;

    // F1: 300 bytes over three slots (R1, R5, R6, R12)
    exp_q.push_back({32'h104, 32'h0000_4000});
    exp_q.push_back({32'h10C, 32'h0000_0000});
    exp_q.push_back({32'h114, 32'h0000_812C});
    send_frame(1, 300);
    check_seg("R1 first buffer data", 1, 0, 128, 32'h400);
    check_seg("R1 second buffer data", 1, 128, 128, 32'h480);
    check_seg("R8 third buffer data", 1, 256, 44, 32'h500);
    check_clean("R9 bytes past 300-byte end untouched", 32'h500 + 44, 84);
    chk(m[32'h10C >> 2] == 32'h0, "R1 middle status", m[32'h10C >> 2], 32'h0);
    chk(m[32'h100 >> 2] == 32'h401, "R3 owner bit slot 0", m[32'h100 >> 2], 32'h401);

    // F2: 61 bytes with flags into the wrap slot (R7, R8, R9)
    in_bcast = 1'b1; in_amatch = 4'b1001; in_tmatch = 1'b1;
    exp_q.push_back({32'h11C, 32'h84C0_C03D});
    send_frame(2, 61);
    in_bcast = 1'b0; in_amatch = '0; in_tmatch = 1'b0;
    chk(m[32'h11C >> 2] == 32'h84C0_C03D, "R7 match flag positions", m[32'h11C >> 2], 32'h84C0_C03D);
    check_seg("R8 masked buffer address data", 2, 0, 61, 32'h580);
    check_clean("R9 partial word bytes untouched", 32'h580 + 61, 67);
    chk(m[32'h118 >> 2] == 32'h583, "R3 wrap bit kept on writeback", m[32'h118 >> 2], 32'h583);

    // F3: slot 0 still owned after wrap: whole frame dropped (R2)
    wr0 = n_wr; ov0 = n_ovr;
    send_frame(3, 50);
    chk(n_wr == wr0, "R2 no writes on owned slot", 32'(n_wr - wr0), 32'h0);
    chk(n_ovr == ov0 + 1, "R2 single overrun pulse", 32'(n_ovr - ov0), 32'h1);

    // F4: release slot 0; same slot reused (R2, R4)
    poke(32'h100, 32'h400);
    exp_q.push_back({32'h104, 32'h0000_C014});
    send_frame(4, 20);
    check_seg("R4 frame after wrap lands in slot 0", 4, 0, 20, 32'h400);

    // F5: slot 1 released, slot 2 still owned: cut mid-frame (R10)
    poke(32'h108, 32'h480);
    ov0 = n_ovr;
    exp_q.push_back({32'h10C, 32'h0000_4000});
    send_frame(5, 200);
    chk(n_ovr == ov0 + 1, "R10 overrun on continuation", 32'(n_ovr - ov0), 32'h1);
    check_seg("R10 filled buffer kept", 5, 0, 128, 32'h480);
    chk(m[32'h108 >> 2] == 32'h481, "R10 filled slot owned", m[32'h108 >> 2], 32'h481);
    chk(m[32'h110 >> 2] == 32'h501, "R10 owned slot untouched", m[32'h110 >> 2], 32'h501);

    // F6: disabled engine holds off, then frame lands in slot 2 (R11, R10)
    poke(32'h110, 32'h500);
    en = 1'b0; wr0 = n_wr; saw_ready = 1'b0;
    in_valid = 1'b1; in_data = pat(6, 0); in_last = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk); #1;
      if (in_ready || mem_req) saw_ready = 1'b1;
    end
    chk(!saw_ready && n_wr == wr0, "R11 disabled engine idle", {31'b0, saw_ready}, 32'h0);
    en = 1'b1;
    exp_q.push_back({32'h114, 32'h0000_C080});
    send_frame(6, 128);
    check_seg("R10 position held on owned slot", 6, 0, 128, 32'h500);
    chk(m[32'h110 >> 2] == 32'h501, "R3 slot 2 returned", m[32'h110 >> 2], 32'h501);
    chk(exp_q.size() == 0, "R6 all status writes seen", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R12 run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule